// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the 13-bit instruction address of a small 8-bit microcontroller core. The low byte of the count can be read and written by software, but software can never reach the upper five bits directly. Those bits are staged in a 5-bit holding latch and only move into the count when the core performs a load.

Two kinds of load read the holding latch. A write to the low byte carrying an ALU result copies all five latch bits into bits 12..8. A jump or call carrying an 11-bit target copies only latch bits 4..3 into bits 12..11. A restore from the return stack, and an interrupt acknowledge that vectors to a fixed address, replace the whole count and leave the latch alone. When no load is requested the count either advances by one per instruction cycle or holds.

Adding an offset to the low byte never carries into the upper bits. A computed branch therefore stays inside the current 256-word block unless software has updated the latch first. Instruction decode, program memory, return stack storage and interrupt control sit outside this block.

Top module: `paged_pc`

## Requirements
- R1: A synchronous active-high reset clears both the count and the holding latch to zero. The first low-byte write after reset therefore yields an upper byte of 0.
- R2: With `adv` high and no load strobe, the count increases by one per cycle. It carries across the byte boundary and wraps from 0x1FFF to 0x0000.
- R3: With no load strobe and `adv` low, the count keeps its value. A latch write on its own does not change the count.
- R4: `lo_wr` sets bits 7..0 to `alu_res` and bits 12..8 to latch bits 4..0, with no carry from the low byte.
- R5: `jmp` sets bits 10..0 to `jmp_tgt` and bits 12..11 to latch bits 4..3. Latch bits 2..0 have no effect on the result.
- R6: `ret_ld` loads `ret_val` into all 13 bits and leaves the holding latch unchanged.
- R7: `irq_ack` loads the fixed vector `IRQ_VEC` (default 0x004) into all 13 bits.
- R8: When strobes coincide, the source is chosen in this priority: `irq_ack`, then `ret_ld`, then `jmp`, then `lo_wr`, then `adv`.
- R9: When `hold_wr` and a load happen in the same cycle, the load uses the latch value from before that cycle. The new latch value applies to later loads.
- R10: `pc_lo` always equals bits 7..0 of `pc`, and both are registered outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Increment enable for one instruction cycle |
| lo_wr | input | 1 | Low-byte write strobe |
| alu_res | input | 8 | ALU result for a low-byte write |
| jmp | input | 1 | Jump/call strobe |
| jmp_tgt | input | 11 | Address field of the jump/call opcode |
| hold_wr | input | 1 | Holding latch write strobe |
| hold_din | input | 5 | Holding latch write data |
| ret_ld | input | 1 | Full load from the return stack |
| ret_val | input | 13 | Restored address |
| irq_ack | input | 1 | Interrupt acknowledge, loads the vector |
| pc | output | 13 | Full program counter |
| pc_lo | output | 8 | Readable low byte |

## Verification
The latch has no output, so the hardest state to reach is its hidden content. The bench brings it out through later loads. A low-byte write exposes all five latch bits, and a jump exposes two of them. This is how the bench shows that a return-stack load left the latch untouched and that a same-cycle latch write did not leak into the load beside it. The sweeps cover all 32 latch values against all 256 low-byte values, and all four page values against all 2048 jump targets. A further sweep drives all 32 combinations of the five strobes to check priority.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;
  typedef enum logic [2:0] {
    SRC_KEEP = 3'd0,
    SRC_INC  = 3'd1,
    SRC_LOW  = 3'd2,
    SRC_JMP  = 3'd3,
    SRC_RET  = 3'd4,
    SRC_IRQ  = 3'd5
  } pc_src_e;
endpackage

// File: rtl/pc_hold_latch.sv
module pc_hold_latch #(
  parameter int HI_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [HI_W-1:0] din,
  output logic [HI_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= din;
  end
endmodule

// File: rtl/pc_src_arbiter.sv
module pc_src_arbiter
  import paged_pc_pkg::*;
(
  input  logic    adv,
  input  logic    lo_wr,
  input  logic    jmp,
  input  logic    ret_ld,
  input  logic    irq_ack,
  output pc_src_e src
);
  always_comb begin
    if (irq_ack)     src = SRC_IRQ;
    else if (ret_ld) src = SRC_RET;
    else if (jmp)    src = SRC_JMP;
    else if (lo_wr)  src = SRC_LOW;
    else if (adv)    src = SRC_INC;
    else             src = SRC_KEEP;
  end
endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
  import paged_pc_pkg::*;
#(
  parameter int PC_W = 13,
  parameter int LO_W = 8,
  parameter int JMP_W = 11,
  parameter logic [PC_W-1:0] IRQ_VEC = 'h004,
  localparam int HI_W = PC_W - LO_W,
  localparam int PG_W = PC_W - JMP_W
) (
  input  pc_src_e          src,
  input  logic [PC_W-1:0]  cur,
  input  logic [HI_W-1:0]  latch,
  input  logic [LO_W-1:0]  alu_res,
  input  logic [JMP_W-1:0] jmp_tgt,
  input  logic [PC_W-1:0]  ret_val,
  output logic [PC_W-1:0]  nxt
);
  logic [PC_W-1:0] jmp_addr;

  generate
    if (PG_W > 0) begin : g_paged
      assign jmp_addr = {latch[HI_W-1 -: PG_W], jmp_tgt};
    end else begin : g_flat
      assign jmp_addr = jmp_tgt[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_IRQ: nxt = IRQ_VEC;
      SRC_RET: nxt = ret_val;
      SRC_JMP: nxt = jmp_addr;
      SRC_LOW: nxt = {latch, alu_res};
      SRC_INC: nxt = cur + PC_W'(1);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/paged_pc.sv
module paged_pc
  import paged_pc_pkg::*;
#(
  parameter int PC_W = 13,
  parameter int LO_W = 8,
  parameter int JMP_W = 11,
  parameter logic [PC_W-1:0] IRQ_VEC = 'h004,
  localparam int HI_W = PC_W - LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             lo_wr,
  input  logic [LO_W-1:0]  alu_res,
  input  logic             jmp,
  input  logic [JMP_W-1:0] jmp_tgt,
  input  logic             hold_wr,
  input  logic [HI_W-1:0]  hold_din,
  input  logic             ret_ld,
  input  logic [PC_W-1:0]  ret_val,
  input  logic             irq_ack,
  output logic [PC_W-1:0]  pc,
  output logic [LO_W-1:0]  pc_lo
);
  pc_src_e         src;
  logic [HI_W-1:0] latch_q;
  logic [PC_W-1:0] pc_nxt;

  pc_hold_latch #(.HI_W(HI_W)) u_latch (
    .clk(clk), .rst(rst), .wr_en(hold_wr), .din(hold_din), .q(latch_q)
  );

  pc_src_arbiter u_arb (
    .adv(adv), .lo_wr(lo_wr), .jmp(jmp), .ret_ld(ret_ld),
    .irq_ack(irq_ack), .src(src)
  );

  pc_next_mux #(
    .PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W), .IRQ_VEC(IRQ_VEC)
  ) u_mux (
    .src(src), .cur(pc), .latch(latch_q), .alu_res(alu_res),
    .jmp_tgt(jmp_tgt), .ret_val(ret_val), .nxt(pc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      pc_lo <= '0;
    end else begin
      pc    <= pc_nxt;
      pc_lo <= pc_nxt[LO_W-1:0];
    end
  end
endmodule

// File: rtl/paged_pc_chk.sv
module paged_pc_chk #(
  parameter int PC_W = 13,
  parameter int LO_W = 8,
  parameter int JMP_W = 11,
  parameter logic [PC_W-1:0] IRQ_VEC = 'h004
) (
  input logic             clk,
  input logic             rst,
  input logic             adv,
  input logic             lo_wr,
  input logic [LO_W-1:0]  alu_res,
  input logic             jmp,
  input logic [JMP_W-1:0] jmp_tgt,
  input logic             ret_ld,
  input logic [PC_W-1:0]  ret_val,
  input logic             irq_ack,
  input logic [PC_W-1:0]  pc,
  input logic [LO_W-1:0]  pc_lo
);
  logic no_load;
  assign no_load = !lo_wr && !jmp && !ret_ld && !irq_ack;

  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (no_load && adv) |=> pc == $past(pc) + PC_W'(1));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (no_load && !adv) |=> $stable(pc));

  a_r4_low_write: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && !jmp && !ret_ld && !irq_ack) |=> pc[LO_W-1:0] == $past(alu_res));

  a_r5_jump_field: assert property (@(posedge clk) disable iff (rst)
    (jmp && !ret_ld && !irq_ack) |=> pc[JMP_W-1:0] == $past(jmp_tgt));

  a_r6_restore: assert property (@(posedge clk) disable iff (rst)
    (ret_ld && !irq_ack) |=> pc == $past(ret_val));

  a_r7_vector: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> pc == IRQ_VEC);

  a_r10_low_mirror: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc_lo == pc[LO_W-1:0]);
endmodule

bind paged_pc paged_pc_chk #(
  .PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk(clk), .rst(rst), .adv(adv), .lo_wr(lo_wr), .alu_res(alu_res),
  .jmp(jmp), .jmp_tgt(jmp_tgt), .ret_ld(ret_ld), .ret_val(ret_val),
  .irq_ack(irq_ack), .pc(pc), .pc_lo(pc_lo)
);

// File: tb/paged_pc_bench.sv
module paged_pc_bench;
  localparam logic [12:0] VEC = 13'h004;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv = 1'b0, lo_wr = 1'b0, jmp = 1'b0;
  logic        hold_wr = 1'b0, ret_ld = 1'b0, irq_ack = 1'b0;
  logic [7:0]  alu_res = '0;
  logic [10:0] jmp_tgt = '0;
  logic [4:0]  hold_din = '0;
  logic [12:0] ret_val = '0;
  logic [12:0] pc;
  logic [7:0]  pc_lo;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [12:0] exp_pc;
  logic [4:0]  exp_lat;

  always #4 clk = ~clk;

  paged_pc u_paged_pc (
    .clk(clk), .rst(rst), .adv(adv), .lo_wr(lo_wr), .alu_res(alu_res),
    .jmp(jmp), .jmp_tgt(jmp_tgt), .hold_wr(hold_wr), .hold_din(hold_din),
    .ret_ld(ret_ld), .ret_val(ret_val), .irq_ack(irq_ack),
    .pc(pc), .pc_lo(pc_lo)
  );

  task automatic compare(input string tag);
    checks++;
    if (pc !== exp_pc || pc_lo !== exp_pc[7:0]) begin
      fails++;
      $display("FAIL %s: pc=%h pc_lo=%h expected pc=%h pc_lo=%h",
               tag, pc, pc_lo, exp_pc, exp_pc[7:0]);
    end
  endtask

  // Drive one cycle at a falling edge, predict, and check at the next falling edge.
  task automatic step(input logic a, input logic lw, input logic [7:0] alu,
                      input logic j, input logic [10:0] t,
                      input logic hw, input logic [4:0] hd,
                      input logic rl, input logic [12:0] rv,
                      input logic ia, input string tag);
    adv = a; lo_wr = lw; alu_res = alu; jmp = j; jmp_tgt = t;
    hold_wr = hw; hold_din = hd; ret_ld = rl; ret_val = rv; irq_ack = ia;
    if (ia)      exp_pc = VEC;
    else if (rl) exp_pc = rv;
    else if (j)  exp_pc = {exp_lat[4:3], t};
    else if (lw) exp_pc = {exp_lat, alu};
    else if (a)  exp_pc = (exp_pc + 13'd1) % 13'h1FFF + ((exp_pc == 13'h1FFE) ? 13'h1FFF : 13'd0);
    if (hw) exp_lat = hd;
    @(negedge clk);
    adv = 0; lo_wr = 0; jmp = 0; hold_wr = 0; ret_ld = 0; irq_ack = 0;
    compare(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_pc = '0;
    exp_lat = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    compare("R1 reset pc");
    step(0,1,8'h5A,0,0,0,0,0,0,0,"R1 latch cleared");
    step(0,0,0,0,0,0,0,0,0,0,"R3 idle");
    step(0,0,0,0,0,1,5'h13,0,0,0,"R3 latch write alone");

    // R4: every latch value against every low-byte value
    for (int l = 0; l < 32; l++) begin
      step(0,0,0,0,0,1,5'(l),0,0,0,"R3 latch write");
      for (int v = 0; v < 256; v++)
        step(0,1,8'(v),0,0,0,0,0,0,0,"R4 low write");
    end
    // R4: offset past end of block does not carry into upper bits
    step(0,0,0,0,0,1,5'h07,0,0,0,"R3 latch write");
    step(0,1,8'hFF,0,0,0,0,0,0,0,"R4 low FF");
    step(0,1,8'hFF + 8'h03,0,0,0,0,0,0,0,"R4 no carry");

    // R5: every page against every jump target, low latch bits ignored
    for (int p = 0; p < 4; p++) begin
      step(0,0,0,0,0,1,5'(p*8 + 5),0,0,0,"R3 latch write");
      for (int t = 0; t < 2048; t++)
        step(0,0,0,1,11'(t),0,0,0,0,0,"R5 jump");
    end

    // R2: carry across a byte and wrap at the top
    step(0,0,0,0,0,0,0,1,13'h00FC,0,"R6 restore");
    for (int i = 0; i < 8; i++) step(1,0,0,0,0,0,0,0,0,0,"R2 byte carry");
    step(0,0,0,0,0,0,0,1,13'h1FF8,0,"R6 restore");
    for (int i = 0; i < 16; i++) step(1,0,0,0,0,0,0,0,0,0,"R2 wrap");

    // R6: restore leaves latch untouched
    step(0,0,0,0,0,1,5'h0A,0,0,0,"R3 latch write");
    step(0,0,0,0,0,0,0,1,13'h1234,0,"R6 restore full");
    step(0,1,8'h00,0,0,0,0,0,0,0,"R6 latch kept");

    // R7
    step(1,0,0,0,0,0,0,0,0,1,"R7 vector");

    // R9: same-cycle latch write and load
    step(0,1,8'h33,0,0,1,5'h1C,0,0,0,"R9 old latch used");
    step(0,1,8'h44,0,0,0,0,0,0,0,"R9 new latch later");
    step(0,0,0,1,11'h2AB,1,5'h00,0,0,0,"R9 jump old latch");
    step(0,0,0,1,11'h2AB,0,0,0,0,0,"R9 jump new latch");

    // R8: all strobe combinations
    for (int c = 0; c < 32; c++) begin
      step(0,0,0,0,0,1,5'h15,0,0,0,"R3 latch write");
      step(c[0],c[1],8'hC3,c[2],11'h5A5,0,0,c[3],13'h0ABC,c[4],"R8 priority");
    end

    step(0,0,0,0,0,0,0,0,0,0,"R10 low mirror");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule